// File: doc/BRIEF.md
# Splittable Dual-Half General-Purpose Timer

This block is a counter/timer built from two 16-bit halves, A and B. Software can run the halves as two separate 16-bit timers, or join them into a single 32-bit timer that is driven through half A's registers. Each half can be set to one of four modes: one-shot timeout, periodic timeout, counting edges on an external input, or PWM generation. It can count up or down in the two timeout modes.

A synchronous word-addressed bus writes configuration, load, match, enable, mask and clear values, and reads them back together with the live count. Event pulses from both halves set sticky status bits. These are combined with a mask into one interrupt line.

Each half is sequenced by a two-state machine:
- IDLE holds the count. The *start* transition (IDLE to RUN) happens when the half's enable is set, and it loads the starting count.
- RUN advances the count. The *stop* transition (RUN to IDLE) happens in three cases: software clears the enable, a one-shot timeout occurs, or an edge count reaches its target.

Top module: `gpt_timer`

## Requirements
- R1: After reset, every readable word is zero, both PWM outputs are low, `irq` is low and both halves are in IDLE. The word addresses are: 0 config, 1 enable, 2 load A, 3 load B, 4 match A, 5 match B, 6 count A, 7 count B, 8 status, 9 mask, 10 clear.
- R2: Down-counting timeout mode uses these encodings. Config bit 0 = join. Bits 2:1 = mode of A and bit 3 = A counts up. Bits 5:4 = mode of B and bit 6 = B counts up. Mode codes are 0 one-shot, 1 periodic, 2 edge, 3 PWM. Enable word bit 0 = A and bit 1 = B. In this mode the count equals the load value L in the first cycle after start and decrements to 0. Periodic mode then reloads L, so the period is L+1 cycles. One-shot mode holds 0 and clears its enable bit.
- R3: When counting up in a timeout mode, the count starts at 0 and rises to L. The timeout fires when the count equals L. Periodic mode restarts from 0. One-shot mode holds L and clears its enable bit.
- R4: In the timeout modes, a match status bit is set when the running count equals the match value. If the match value is never reached, the bit stays clear.
- R5: In edge mode, the count loads L and decreases by one for each rising edge of the half's edge input, after a two-flop synchronizer. When the count equals the match value M, the half stops. It sets its edge-done status bit and clears its enable bit. This means exactly L−M edges are counted, and later edges are ignored.
- R6: In PWM mode, the count runs L down to 0 and then reloads. The output goes high on each load and low after the count equals M, for nonzero M. The result is high for L−M+1 of every L+1 cycles. With M = 0 the output stays high. The output is low while the half is disabled.
- R7: When joined, a write to load A stores all 32 bits: the upper 16 bits become half B's load word. Load A reads back 32 bits, and half A counts over the full 32-bit range.
- R8: When joined, writes to load B are ignored. Reads of load B return the upper 16 bits of the running 32-bit count.
- R9: When split, load B stores and returns only bits 15:0, and load A's upper 16 bits read as zero.
- R10: When joined, match A reads 32 bits, and its upper half is match B. When split, the upper 16 bits of match A read as zero, and writing them leaves match B unchanged.
- R11: The status bits are sticky: bit 0 A timeout, 1 A match, 2 A edge-done, 3 B timeout, 4 B match, 5 B edge-done. Writing 1 to the matching bit of the clear word clears that bit.
- R12: `irq` is high exactly when some status bit and its mask bit (same position, mask word) are both 1.
- R13: When split, the two halves run at the same time without affecting each other's count or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| edge_in_a | input | 1 | Edge input for half A (or the joined timer) |
| edge_in_b | input | 1 | Edge input for half B |
| pwm_a | output | 1 | PWM output of half A |
| pwm_b | output | 1 | PWM output of half B |
| irq | output | 1 | Masked OR of the status bits |

## Verification
Both halves are swept in each timeout mode, in both directions, across several load values including 0 and 1. Each count is compared every cycle with an arithmetic prediction. This separates the reload cycle of a periodic timer from the hold behaviour of a one-shot timer, and it shows the off-by-one at the period boundary.

The edge, PWM and joined patterns are aimed at specific differences:
- The edge pattern separates counting that stops at the target from counting that runs on.
- The PWM high-time totals over whole periods separate the duty formula from its neighbours, and M = 0 is covered as its own case.
- In the joined pattern, the load value sits just above 16 bits, so each count is checked as it crosses the 16-bit boundary.

The register patterns check that words mirror each other when joined and stay independent when split.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int ADDR_W   = 4;
    localparam int NUM_SRC  = 6;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_EDGE     = 2'd2,
        MODE_PWM      = 2'd3
    } gpt_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gpt_state_e;

    localparam logic [ADDR_W-1:0] ADR_CFG    = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_LOADA  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_LOADB  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_MATCHA = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_MATCHB = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_VALA   = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_VALB   = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_CLR    = 4'd10;

endpackage

// File: rtl/gpt_edge_sync.sv
module gpt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], din};
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
    import gpt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  gpt_mode_e     mode,
    input  logic          up,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] match_val,
    input  logic          edge_pulse,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          timeout,
    output logic          match_hit,
    output logic          edge_done,
    output logic          halt,
    output logic          pwm
);
    localparam logic [CW-1:0] ONE = CW'(1);

    gpt_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          pwm_q;
    logic          is_tmr, at_end, live;

    assign is_tmr    = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
    assign at_end    = up ? (cnt_q == load_val) : (cnt_q == '0);
    assign live      = (state_q == ST_RUN) && en;
    assign timeout   = live && is_tmr && at_end;
    assign match_hit = live && is_tmr && (cnt_q == match_val);
    assign edge_done = live && (mode == MODE_EDGE) && (cnt_q == match_val);
    assign halt      = (timeout && (mode == MODE_ONESHOT)) || edge_done;
    assign running   = (state_q == ST_RUN);
    assign cnt       = cnt_q;
    assign pwm       = pwm_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = ST_RUN;
            ST_RUN:  if (!en || halt) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (en) begin
                        cnt_q <= (is_tmr && up) ? '0 : load_val;
                        pwm_q <= (mode == MODE_PWM);
                    end else begin
                        pwm_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (!en) begin
                        pwm_q <= 1'b0;
                    end else begin
                        unique case (mode)
                            MODE_ONESHOT, MODE_PERIODIC: begin
                                if (at_end) begin
                                    if (mode == MODE_PERIODIC)
                                        cnt_q <= up ? '0 : load_val;
                                end else begin
                                    cnt_q <= up ? cnt_q + ONE : cnt_q - ONE;
                                end
                            end
                            MODE_EDGE: begin
                                if (!edge_done && edge_pulse)
                                    cnt_q <= cnt_q - ONE;
                            end
                            MODE_PWM: begin
                                if (cnt_q == '0) begin
                                    cnt_q <= load_val;
                                    pwm_q <= 1'b1;
                                end else begin
                                    cnt_q <= cnt_q - ONE;
                                    if (cnt_q == match_val) pwm_q <= 1'b0;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*W-1:0]      bus_wdata,
    output logic [2*W-1:0]      bus_rdata,
    input  logic                edge_in_a,
    input  logic                edge_in_b,
    output logic                pwm_a,
    output logic                pwm_b,
    output logic                irq
);
    localparam int DW = 2 * W;

    logic            cfg_join, up_a, up_b;
    gpt_mode_e       mode_a, mode_b;
    logic            en_a_q, en_b_q, b_en;
    logic [W-1:0]    ld_lo, ld_hi, mt_lo, mt_hi;
    logic [NUM_SRC-1:0] stat_q, mask_q, src, clr_bits;
    logic [1:0]      edge_raw, edge_pulse;
    logic [DW-1:0]   load_a, match_a, cnt_a;
    logic [W-1:0]    cnt_b;
    logic            a_run, a_timeout, a_match, a_edge_done, a_halt;
    logic            b_run, b_timeout, b_match, b_edge_done, b_halt;
    logic            wr_ctrl;

    assign edge_raw = {edge_in_b, edge_in_a};

    for (genvar i = 0; i < 2; i++) begin : g_sync
        gpt_edge_sync #(.STAGES(2)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (edge_raw[i]),
            .rise (edge_pulse[i])
        );
    end

    assign load_a  = cfg_join ? {ld_hi, ld_lo} : {{W{1'b0}}, ld_lo};
    assign match_a = cfg_join ? {mt_hi, mt_lo} : {{W{1'b0}}, mt_lo};
    assign b_en    = en_b_q && !cfg_join;

    gpt_counter #(.CW(DW)) u_half_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_a_q),
        .mode      (mode_a),
        .up        (up_a),
        .load_val  (load_a),
        .match_val (match_a),
        .edge_pulse(edge_pulse[0]),
        .cnt       (cnt_a),
        .running   (a_run),
        .timeout   (a_timeout),
        .match_hit (a_match),
        .edge_done (a_edge_done),
        .halt      (a_halt),
        .pwm       (pwm_a)
    );

    gpt_counter #(.CW(W)) u_half_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (b_en),
        .mode      (mode_b),
        .up        (up_b),
        .load_val  (ld_hi),
        .match_val (mt_hi),
        .edge_pulse(edge_pulse[1]),
        .cnt       (cnt_b),
        .running   (b_run),
        .timeout   (b_timeout),
        .match_hit (b_match),
        .edge_done (b_edge_done),
        .halt      (b_halt),
        .pwm       (pwm_b)
    );

    assign src      = {b_edge_done, b_match, b_timeout, a_edge_done, a_match, a_timeout};
    assign clr_bits = (bus_wr && bus_addr == ADR_CLR) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_join <= 1'b0;
            mode_a   <= MODE_ONESHOT;
            up_a     <= 1'b0;
            mode_b   <= MODE_ONESHOT;
            up_b     <= 1'b0;
            ld_lo    <= '0;
            ld_hi    <= '0;
            mt_lo    <= '0;
            mt_hi    <= '0;
            mask_q   <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                ADR_CFG: begin
                    cfg_join <= bus_wdata[0];
                    mode_a   <= gpt_mode_e'(bus_wdata[2:1]);
                    up_a     <= bus_wdata[3];
                    mode_b   <= gpt_mode_e'(bus_wdata[5:4]);
                    up_b     <= bus_wdata[6];
                end
                ADR_LOADA: begin
                    ld_lo <= bus_wdata[W-1:0];
                    if (cfg_join) ld_hi <= bus_wdata[DW-1:W];
                end
                ADR_LOADB: begin
                    if (!cfg_join) ld_hi <= bus_wdata[W-1:0];
                end
                ADR_MATCHA: begin
                    mt_lo <= bus_wdata[W-1:0];
                    if (cfg_join) mt_hi <= bus_wdata[DW-1:W];
                end
                ADR_MATCHB: mt_hi  <= bus_wdata[W-1:0];
                ADR_MASK:   mask_q <= bus_wdata[NUM_SRC-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_a_q <= 1'b0;
            en_b_q <= 1'b0;
            stat_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_a_q <= bus_wdata[0];
                en_b_q <= bus_wdata[1];
            end else begin
                if (a_halt) en_a_q <= 1'b0;
                if (b_halt) en_b_q <= 1'b0;
            end
            stat_q <= (stat_q & ~clr_bits) | src;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CFG:    bus_rdata = DW'({up_b, mode_b, up_a, mode_a, cfg_join});
            ADR_CTRL:   bus_rdata = DW'({en_b_q, en_a_q});
            ADR_LOADA:  bus_rdata = load_a;
            ADR_LOADB:  bus_rdata = cfg_join ? {{W{1'b0}}, cnt_a[DW-1:W]} : {{W{1'b0}}, ld_hi};
            ADR_MATCHA: bus_rdata = match_a;
            ADR_MATCHB: bus_rdata = {{W{1'b0}}, mt_hi};
            ADR_VALA:   bus_rdata = cfg_join ? cnt_a : {{W{1'b0}}, cnt_a[W-1:0]};
            ADR_VALB:   bus_rdata = {{W{1'b0}}, cnt_b};
            ADR_STAT:   bus_rdata = DW'(stat_q);
            ADR_MASK:   bus_rdata = DW'(mask_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [2*W-1:0]      bus_wdata,
    input logic                cfg_join,
    input gpt_mode_e           mode_a,
    input logic                en_a_q,
    input logic                a_timeout,
    input logic                a_run,
    input logic [2*W-1:0]      cnt_a,
    input logic [1:0]          edge_pulse,
    input logic [W-1:0]        ld_hi,
    input logic [W-1:0]        mt_hi,
    input logic [NUM_SRC-1:0]  stat_q,
    input logic [NUM_SRC-1:0]  mask_q,
    input logic                irq,
    input logic                b_run,
    input logic                b_en,
    input logic                pwm_b
);
    // R2
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_timeout && mode_a == MODE_ONESHOT && !(bus_wr && bus_addr == ADR_CTRL)) |=> !en_a_q);

    // R8
    ldb_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_LOADB && cfg_join) |=> $stable(ld_hi));

    // R10
    mhi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_MATCHA && !cfg_join) |=> $stable(mt_hi));

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_run && en_a_q && mode_a == MODE_EDGE && !edge_pulse[0] && !bus_wr) |=> $stable(cnt_a));

    // R6
    pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_run && !b_en) |=> !pwm_b);

    // R12
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_sticky
        // R11
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[k] && !(bus_wr && bus_addr == ADR_CLR && bus_wdata[k])) |=> stat_q[k]);
    end
endmodule

bind gpt_timer gpt_timer_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cfg_join  (cfg_join),
    .mode_a    (mode_a),
    .en_a_q    (en_a_q),
    .a_timeout (a_timeout),
    .a_run     (a_run),
    .cnt_a     (cnt_a),
    .edge_pulse(edge_pulse),
    .ld_hi     (ld_hi),
    .mt_hi     (mt_hi),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq       (irq),
    .b_run     (b_run),
    .b_en      (b_en),
    .pwm_b     (pwm_b)
);

// File: tb/test_gpt_timer.sv
module test_gpt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        edge_in_a = 1'b0;
    logic        edge_in_b = 1'b0;
    logic        pwm_a, pwm_b, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpt_timer i_gpt_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .edge_in_a(edge_in_a),
        .edge_in_b(edge_in_b),
        .pwm_a    (pwm_a),
        .pwm_b    (pwm_b),
        .irq      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_edge_a(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); edge_in_a = 1'b1;
            repeat (3) @(negedge clk);
            edge_in_a = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // Timeout-mode sweep: md 0 one-shot / 1 periodic, up 0/1, load L
    task automatic sweep(input int half, input int md, input int up, input int L);
        logic [31:0] v;
        int exp;
        int cfgv;
        string tag;
        tag  = up ? "R3 up count" : "R2 down count";
        cfgv = (half == 0) ? ((md << 1) | (up << 3)) : ((md << 4) | (up << 6));
        wr(4'd1, 0);
        wr(4'd0, cfgv);
        wr(half ? 4'd3 : 4'd2, L);
        wr(4'd1, half ? 2 : 1);
        for (int m = 1; m <= 2 * (L + 1) + 2; m++) begin
            @(negedge clk);
            rd(half ? 4'd7 : 4'd6, v);
            if (md == 1) begin
                exp = up ? ((m - 1) % (L + 1)) : (L - ((m - 1) % (L + 1)));
            end else begin
                if (m - 1 <= L) exp = up ? (m - 1) : (L - (m - 1));
                else            exp = up ? L : 0;
            end
            chk(tag, v, exp);
        end
        if (md == 0) begin
            rd(4'd1, v);
            chk(up ? "R3 one-shot enable cleared" : "R2 one-shot enable cleared", v[half], 0);
        end
        wr(4'd1, 0);
    endtask

    initial begin
        logic [31:0] v;
        int hi_cnt;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a <= 10; a++) begin
            rd(a[3:0], v);
            chk("R1 reset word", v, 0);
        end
        chk("R1 reset irq", irq, 0);
        chk("R1 reset pwm_a", pwm_a, 0);
        chk("R1 reset pwm_b", pwm_b, 0);

        // R2 / R3 sweeps on both halves
        for (int half = 0; half < 2; half++)
            for (int md = 0; md < 2; md++)
                for (int up = 0; up < 2; up++) begin
                    sweep(half, md, up, 0);
                    sweep(half, md, up, 1);
                    sweep(half, md, up, 3);
                    sweep(half, md, up, 6);
                end

        // R4 match reached, R11 sticky/clear, R12 masking
        wr(4'd10, 32'h3F);
        wr(4'd0, 32'h2);
        wr(4'd2, 7);
        wr(4'd4, 3);
        wr(4'd1, 1);
        repeat (20) @(negedge clk);
        wr(4'd1, 0);
        repeat (3) @(negedge clk);
        rd(4'd8, v);
        chk("R4 match and timeout flags", v, 32'h3);
        chk("R12 irq low with mask clear", irq, 0);
        wr(4'd9, 32'h2);
        chk("R12 irq high with mask bit", irq, 1);
        wr(4'd10, 32'h1);
        rd(4'd8, v);
        chk("R11 clear one bit only", v, 32'h2);
        chk("R12 irq still high", irq, 1);
        wr(4'd10, 32'h2);
        rd(4'd8, v);
        chk("R11 cleared", v, 0);
        chk("R12 irq low after clear", irq, 0);

        // R4 match never reached
        wr(4'd2, 5);
        wr(4'd4, 9);
        wr(4'd1, 1);
        repeat (20) @(negedge clk);
        wr(4'd1, 0);
        repeat (3) @(negedge clk);
        rd(4'd8, v);
        chk("R4 no match flag", v, 32'h1);
        wr(4'd10, 32'h3F);
        wr(4'd9, 0);

        // R5 edge counting
        wr(4'd0, 32'h4);
        wr(4'd2, 10);
        wr(4'd4, 4);
        wr(4'd1, 1);
        repeat (3) @(negedge clk);
        pulse_edge_a(3);
        repeat (3) @(negedge clk);
        rd(4'd6, v);
        chk("R5 count after three edges", v, 7);
        pulse_edge_a(3);
        repeat (3) @(negedge clk);
        rd(4'd6, v);
        chk("R5 stopped at match", v, 4);
        rd(4'd1, v);
        chk("R5 enable cleared", v[0], 0);
        rd(4'd8, v);
        chk("R5 edge-done flag", v[2], 1);
        pulse_edge_a(2);
        repeat (3) @(negedge clk);
        rd(4'd6, v);
        chk("R5 later edges ignored", v, 4);
        wr(4'd10, 32'h3F);

        // R6 PWM on B with R13 A periodic alongside
        wr(4'd0, 32'h32);
        wr(4'd2, 4);
        wr(4'd4, 9);
        wr(4'd3, 9);
        wr(4'd5, 3);
        wr(4'd1, 3);
        hi_cnt = 0;
        for (int m = 1; m <= 30; m++) begin
            @(negedge clk);
            hi_cnt += pwm_b;
            rd(4'd6, v);
            chk("R13 A periodic beside B PWM", v, 4 - ((m - 1) % 5));
        end
        chk("R6 PWM high cycles M=3", hi_cnt, 21);
        wr(4'd1, 0);
        wr(4'd5, 0);
        wr(4'd1, 2);
        hi_cnt = 0;
        for (int m = 1; m <= 30; m++) begin
            @(negedge clk);
            hi_cnt += pwm_b;
        end
        chk("R6 PWM high cycles M=0", hi_cnt, 30);
        wr(4'd1, 0);
        repeat (3) @(negedge clk);
        chk("R6 PWM low when disabled", pwm_b, 0);
        chk("R13 pwm_a unaffected", pwm_a, 0);

        // R7 / R8 joined mode
        wr(4'd0, 32'h3);
        wr(4'd2, 32'h0001_0002);
        rd(4'd2, v);
        chk("R7 joined load read", v, 32'h0001_0002);
        rd(4'd3, v);
        chk("R8 load B reads count upper", v, 0);
        wr(4'd3, 32'h1234);
        rd(4'd2, v);
        chk("R8 load B write ignored", v, 32'h0001_0002);
        wr(4'd1, 1);
        for (int m = 1; m <= 8; m++) begin
            @(negedge clk);
            rd(4'd6, v);
            chk("R7 joined count", v, 32'h0001_0002 - (m - 1));
            rd(4'd3, v);
            chk("R8 load B tracks count", v, (32'h0001_0002 - (m - 1)) >> 16);
        end
        wr(4'd1, 0);

        // R10 match words
        wr(4'd4, 32'hABCD_1234);
        rd(4'd4, v);
        chk("R10 joined match A", v, 32'hABCD_1234);
        rd(4'd5, v);
        chk("R10 joined match B", v, 32'h0000_ABCD);
        wr(4'd0, 32'h0);
        rd(4'd4, v);
        chk("R10 split match A upper zero", v, 32'h0000_1234);
        wr(4'd4, 32'h5555_0777);
        rd(4'd4, v);
        chk("R10 split match A", v, 32'h0000_0777);
        rd(4'd5, v);
        chk("R10 match B unchanged", v, 32'h0000_ABCD);

        // R9 split load words
        wr(4'd3, 32'hFFFF_0033);
        rd(4'd3, v);
        chk("R9 split load B", v, 32'h0000_0033);
        rd(4'd2, v);
        chk("R9 split load A upper zero", v, 32'h0000_0002);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual unfinished, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule